// File: doc/BRIEF.md
# Multiport Repeater Forwarding Core

This block is the central repeat engine of an unmanaged repeater unit with several local ports and one cascade expansion port. Each cycle of the 25 MHz symbol clock it samples the receive activity and the 5-bit symbol of every local port. It also samples the activity lines of cascaded peer devices, the symbol that arrives on the expansion data bus, and a shared active-low collision line. From these samples it picks the single data source. It then builds a transmit enable and a transmit symbol for every local port, plus an enable and a symbol for the expansion bus.

When one local port is the only source, the other local ports and the expansion bus repeat its symbols. When only a peer is active, every local port repeats the expansion symbol. When two or more sources overlap, or the shared collision line is asserted, every local port sends a fixed jam code group. The jam lasts until all sources have gone quiet for a full symbol clock. Fault guards outside the block can mark a port as receive-ignored, so that it is not counted as a source, or as transmit-blocked, so that it is never enabled. The block drives an active-low local activity line for its peers and an active-low collision line for the shared bus.

Top module: `rep_core`

## Requirements
- R1: When exactly one counted local port is active and no collision state is in force, every other unblocked port gets `tx_en` with that port's symbol on its lane, and `exp_tx_en` is 1 with the same symbol on `exp_tx_data`. The source port itself gets no enable. Lane p is bits [p*5 +: 5].
- R2: When no counted local port is active and at least one bit of `peer_act_n` is 0, with no collision, every unblocked local port is enabled with `exp_rx_data`, and `exp_tx_en` is 0.
- R3: When two or more sources are active at once, every unblocked local port is enabled with the jam code `JAM_SYM` (default 5'b10101) and `exp_tx_en` is 0. A source is a counted local port, or any peer line.
- R4: Once jam has started, it continues while any source remains active. It also covers the first cycle in which all sources and the collision input are idle, and it ends the cycle after that.
- R5: `lact_out_n` is 0 exactly when at least one counted local port was active at the previous rising edge.
- R6: `col_out_n` is 0 when two or more counted local ports are active, or when one counted local port and a peer are active together. It stays 1 for peer activity alone and for the collision input alone.
- R7: A 0 on `col_in_n` forces jam on all unblocked local ports, even with no local or peer activity.
- R8: A port with `rx_ignore` set is not counted as a source. It does not drive `lact_out_n` and does not cause forwarding or collision, but it still receives data repeated from other sources.
- R9: A port with `tx_block` set never gets `tx_en`, in forwarding or in jam.
- R10: All inputs are sampled on the rising clock edge, and the outputs reflect the inputs of the previous edge. During reset all enables are 0 and both active-low outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Active-low reset |
| rx_act | input | NPORT | Per-port receive activity |
| rx_data | input | NPORT*SYMW | Per-port received symbols, lane p at [p*SYMW +: SYMW] |
| rx_ignore | input | NPORT | Fault guard: do not count this port as a source |
| tx_block | input | NPORT | Fault guard: never enable transmit on this port |
| exp_rx_data | input | SYMW | Symbol arriving on the expansion bus |
| peer_act_n | input | NPEER | Active-low activity from cascaded peers |
| col_in_n | input | 1 | Active-low shared collision input |
| tx_en | output | NPORT | Per-port transmit enable |
| tx_data | output | NPORT*SYMW | Per-port transmit symbols |
| exp_tx_en | output | 1 | Drive the expansion data bus |
| exp_tx_data | output | SYMW | Symbol driven onto the expansion bus |
| lact_out_n | output | 1 | Active-low local activity output |
| col_out_n | output | 1 | Active-low collision output |

## Verification
On every cycle the assertions check four things. A blocked port never transmits. The expansion bus is driven only while local activity is reported and no collision is flagged. A flagged collision is followed by a jam cycle. The local activity output tracks the counted activity of the previous edge. The bench's scenarios show the rest: which symbol reaches which lane, the one-cycle jam tail after a collision and its end, jam forced by the collision input alone, and ignored ports dropping out of arbitration.

// File: rtl/rep_core.sv
module rep_core #(
  parameter int NPORT = 4,
  parameter int SYMW = 5,
  parameter int NPEER = 5,
  parameter bit [SYMW-1:0] JAM_SYM = SYMW'(21)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        rx_act,
  input  logic [NPORT*SYMW-1:0]   rx_data,
  input  logic [NPORT-1:0]        rx_ignore,
  input  logic [NPORT-1:0]        tx_block,
  input  logic [SYMW-1:0]         exp_rx_data,
  input  logic [NPEER-1:0]        peer_act_n,
  input  logic                    col_in_n,
  output logic [NPORT-1:0]        tx_en,
  output logic [NPORT*SYMW-1:0]   tx_data,
  output logic                    exp_tx_en,
  output logic [SYMW-1:0]         exp_tx_data,
  output logic                    lact_out_n,
  output logic                    col_out_n
);
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CW = $clog2(NPORT + 2);

  logic [NPORT-1:0]      s_act, s_ign, s_blk;
  logic [NPORT*SYMW-1:0] s_data;
  logic [SYMW-1:0]       s_xdata;
  logic [NPEER-1:0]      s_peer_n;
  logic                  s_colin_n, col_st, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_act     <= '0;
      s_ign     <= '0;
      s_blk     <= '0;
      s_data    <= '0;
      s_xdata   <= '0;
      s_peer_n  <= '1;
      s_colin_n <= 1'b1;
      armed     <= 1'b0;
    end else begin
      s_act     <= rx_act;
      s_ign     <= rx_ignore;
      s_blk     <= tx_block;
      s_data    <= rx_data;
      s_xdata   <= exp_rx_data;
      s_peer_n  <= peer_act_n;
      s_colin_n <= col_in_n;
      armed     <= 1'b1;
    end
  end

  logic [NPORT-1:0] loc;
  logic [CW-1:0]    loc_cnt;
  logic             peer_any, loc_col, col_now, idle, jam;
  logic [IW-1:0]    src;
  logic [SYMW-1:0]  sel_sym;

  assign loc      = s_act & ~s_ign;
  assign loc_cnt  = CW'($countones(loc));
  assign peer_any = ~&s_peer_n;
  assign loc_col  = (loc_cnt >= CW'(2)) | ((loc_cnt == CW'(1)) & peer_any);
  assign col_now  = loc_col | ~s_colin_n;
  assign idle     = (loc_cnt == '0) & ~peer_any & s_colin_n;
  assign jam      = col_now | col_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_st <= 1'b0;
    else        col_st <= col_now | (col_st & ~idle);
  end

  always_comb begin
    src = '0;
    for (int p = 0; p < NPORT; p++)
      if (loc[p]) src = IW'(p);
  end

  assign sel_sym = s_data[src*SYMW +: SYMW];

  always_comb begin
    tx_en       = '0;
    tx_data     = '0;
    exp_tx_en   = 1'b0;
    exp_tx_data = '0;
    if (jam) begin
      tx_en   = ~s_blk;
      tx_data = {NPORT{JAM_SYM}};
    end else if (loc_cnt == CW'(1)) begin
      tx_en       = ~s_blk & ~(NPORT'(1) << src);
      tx_data     = {NPORT{sel_sym}};
      exp_tx_en   = 1'b1;
      exp_tx_data = sel_sym;
    end else if (peer_any) begin
      tx_en   = ~s_blk;
      tx_data = {NPORT{s_xdata}};
    end
  end

  assign lact_out_n = (loc_cnt == '0);
  assign col_out_n  = ~loc_col;

  a_r9_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((tx_en & $past(tx_block)) == '0));

  a_r1_exp_needs_local: assert property (@(posedge clk) disable iff (!rst_n)
    exp_tx_en |-> (!lact_out_n && col_out_n));

  a_r4_jam_tail: assert property (@(posedge clk) disable iff (!rst_n)
    !col_out_n |=> !exp_tx_en);

  a_r5_lact_follows: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (lact_out_n == ($past(rx_act & ~rx_ignore) == '0)));
endmodule

// File: tb/rep_core_tb.sv
module rep_core_tb_top;
  localparam int NP = 4;
  localparam int W = 5;
  localparam int NPE = 5;
  localparam logic [W-1:0] JAM = 5'b10101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] rx_act = '0, rx_ignore = '0, tx_block = '0;
  logic [NP*W-1:0] rx_data = '0;
  logic [W-1:0] exp_rx_data = '0;
  logic [NPE-1:0] peer_act_n = '1;
  logic col_in_n = 1'b1;
  logic [NP-1:0] tx_en;
  logic [NP*W-1:0] tx_data;
  logic exp_tx_en, lact_out_n, col_out_n;
  logic [W-1:0] exp_tx_data;

  int n_tests = 0, n_fail = 0;
  bit m_col = 1'b0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    logic [NP-1:0] en;
    logic [W-1:0] lane;
    logic xen;
    logic [W-1:0] xd;
    logic lact_n;
    logic col_n;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  rep_core #(.NPORT(NP), .SYMW(W), .NPEER(NPE), .JAM_SYM(JAM)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .rx_data(rx_data),
    .rx_ignore(rx_ignore), .tx_block(tx_block), .exp_rx_data(exp_rx_data),
    .peer_act_n(peer_act_n), .col_in_n(col_in_n), .tx_en(tx_en),
    .tx_data(tx_data), .exp_tx_en(exp_tx_en), .exp_tx_data(exp_tx_data),
    .lact_out_n(lact_out_n), .col_out_n(col_out_n));

  task automatic step(input string tag, input logic [NP-1:0] act,
                      input logic [NP*W-1:0] data, input logic [NP-1:0] ign,
                      input logic [NP-1:0] blk, input logic [W-1:0] xd,
                      input logic [NPE-1:0] pn, input logic cn);
    exp_t e;
    int nloc, src;
    bit pa, cnow, jam;
    @(negedge clk);
    rx_act = act; rx_data = data; rx_ignore = ign; tx_block = blk;
    exp_rx_data = xd; peer_act_n = pn; col_in_n = cn;
    nloc = $countones(act & ~ign);
    src = 0;
    for (int p = 0; p < NP; p++) if (act[p] && !ign[p]) src = p;
    pa = (pn != '1);
    cnow = (nloc >= 2) || (nloc == 1 && pa) || !cn;
    jam = cnow || m_col;
    m_col = cnow || (m_col && !(nloc == 0 && !pa && cn));
    e.tag = tag; e.en = '0; e.lane = '0; e.xen = 1'b0; e.xd = '0;
    e.lact_n = (nloc == 0);
    e.col_n = !((nloc >= 2) || (nloc == 1 && pa));
    if (jam) begin
      e.en = ~blk; e.lane = JAM;
    end else if (nloc == 1) begin
      e.en = ~blk; e.en[src] = 1'b0; e.lane = data[src*W +: W];
      e.xen = 1'b1; e.xd = data[src*W +: W];
    end else if (pa) begin
      e.en = ~blk; e.lane = xd;
    end
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    bit bad;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        bad = (tx_en !== e.en) || (exp_tx_en !== e.xen) ||
              (lact_out_n !== e.lact_n) || (col_out_n !== e.col_n) ||
              (e.xen && exp_tx_data !== e.xd);
        for (int p = 0; p < NP; p++)
          if (e.en[p] && tx_data[p*W +: W] !== e.lane) bad = 1'b1;
        n_tests++;
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got en=%b data=%h xen=%b xd=%h lact_n=%b col_n=%b exp en=%b lane=%h xen=%b xd=%h lact_n=%b col_n=%b",
                   e.tag, tx_en, tx_data, exp_tx_en, exp_tx_data, lact_out_n, col_out_n,
                   e.en, e.lane, e.xen, e.xd, e.lact_n, e.col_n);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [NP*W-1:0] lanes(input logic [W-1:0] d3, d2, d1, d0);
    return {d3, d2, d1, d0};
  endfunction

  initial begin : driver
    repeat (3) @(negedge clk);
    n_tests++;
    if (tx_en !== '0 || exp_tx_en !== 1'b0 || lact_out_n !== 1'b1 || col_out_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 reset: got en=%b xen=%b lact_n=%b col_n=%b exp 0 0 1 1",
               tx_en, exp_tx_en, lact_out_n, col_out_n);
    end
    rst_n = 1'b1;
    step("R10 idle", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R1 port0 source", 4'b0001, lanes(5'h0, 5'h0, 5'h0, 5'h03), '0, '0, 5'h00, '1, 1'b1);
    step("R1 port2 source", 4'b0100, lanes(5'h0, 5'h07, 5'h0, 5'h0), '0, '0, 5'h00, '1, 1'b1);
    step("R2 peer source", 4'b0000, '0, '0, '0, 5'h09, 5'b11011, 1'b1);
    step("R2 peer new data", 4'b0000, '0, '0, '0, 5'h1c, 5'b01111, 1'b1);
    step("R3 R6 two local", 4'b1010, lanes(5'h1, 5'h0, 5'h2, 5'h0), '0, '0, 5'h00, '1, 1'b1);
    step("R4 one remains", 4'b0010, lanes(5'h0, 5'h0, 5'h2, 5'h0), '0, '0, 5'h00, '1, 1'b1);
    step("R4 idle tail", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R4 cleared", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R3 R6 local plus peer", 4'b0001, lanes(5'h0, 5'h0, 5'h0, 5'h0e), '0, '0, 5'h11, 5'b11110, 1'b1);
    step("R4 tail after peer", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R4 cleared again", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R7 R6 col_in only", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b0);
    step("R7 tail", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R7 cleared", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    step("R8 ignored alone", 4'b0100, lanes(5'h0, 5'h0f, 5'h0, 5'h0), 4'b0100, '0, 5'h00, '1, 1'b1);
    step("R8 ignored plus source", 4'b0101, lanes(5'h0, 5'h0f, 5'h0, 5'h12), 4'b0100, '0, 5'h00, '1, 1'b1);
    step("R8 ignored plus peer", 4'b1000, lanes(5'h1f, 5'h0, 5'h0, 5'h0), 4'b1000, '0, 5'h06, 5'b10111, 1'b1);
    step("R9 blocked forward", 4'b0010, lanes(5'h0, 5'h0, 5'h0b, 5'h0), '0, 4'b1000, 5'h00, '1, 1'b1);
    step("R9 blocked jam", 4'b0011, lanes(5'h0, 5'h0, 5'h0b, 5'h04), '0, 4'b0001, 5'h00, '1, 1'b1);
    step("R9 blocked tail", 4'b0000, '0, '0, 4'b0001, 5'h00, '1, 1'b1);
    step("R10 final idle", 4'b0000, '0, '0, '0, 5'h00, '1, 1'b1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule